// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller with Queues

This block moves bytes between a 32-bit register port and a four-wire serial link, in both directions at once. Software writes bytes into a 64-entry transmit queue. The shift engine sends each byte most-significant bit first. The byte that comes back in the same eight clock periods goes into a 64-entry receive queue, where software reads it.

The engine can drive the serial clock itself, from a programmable divider on the system clock. It can also follow an external serial clock and select line. Clock idle level and sampling edge are both selectable. The outgoing select line is either driven by the queue state or set directly from a register bit.

The register port has no back-pressure. A byte written to a full transmit queue is dropped, and a read of an empty receive queue returns zero. Each of these events, and a received byte that finds the receive queue full, sets a sticky flag. Software reads the flags in the status word.

Register map (word address on `reg_addr`):
- 0: configuration
- 1: divider
- 2: select control
- 3: status
- 4: transmit data (write)
- 5: receive data (read)

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, the serial clock output is low, the select output is high, and the status word reads exactly 0x0200_0000, which means done with both levels zero.
- R2: In controller mode (config bit 4 = 0) with transmit and receive enabled (config bits 0 and 1), each byte written to address 4 is shifted out MSB first. The byte shifted in is read back from address 5 in write order.
- R3: The clock idles at config bit 3 (polarity). With config bit 2 (phase) clear, data is sampled on the leading edge; with it set, on the trailing edge. A receiver that samples the data output on those edges recovers each byte sent.
- R4: Status bits 14:6 hold the transmit queue level and bits 23:15 hold the receive queue level, each a count from 0 to 64.
- R5: Status bit 25 is 1 exactly when the transmit queue is empty and no byte is being shifted.
- R6: A write to address 4 while the transmit queue holds 64 bytes is dropped, and the level stays 64. Status bit 0 becomes 1 and stays 1 until soft reset.
- R7: A read of address 5 while the receive queue is empty returns 0 and sets status bit 1, which stays 1 until soft reset.
- R8: When select-control bit 1 is set, the select output is low while the transmit queue is not empty or a byte is in flight, and high otherwise. When bit 1 is clear, the select output follows select-control bit 0.
- R9: While config bit 5 (soft reset) is 1, both queues are emptied, the engine stops, and the sticky flags are cleared.
- R10: With config bit 0 clear, no transfer starts and queued bytes stay queued. With config bit 1 clear, received bytes are discarded.
- R11: In controller mode each half period of the serial clock lasts (divider + 1) system clock cycles.
- R12: In target mode (config bit 4 = 1), the engine shifts on edges of the external serial clock while the external select is low. It drives the queued byte and queues the byte received.
- R13: A received byte that finds the receive queue full is dropped, the older bytes are kept, and status bit 2 becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sclk_o | output | 1 | Serial clock driven in controller mode |
| sdo_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Active-low select output |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | External serial clock for target mode |
| cs_n_i | input | 1 | External active-low select for target mode |

## Verification
The assertions assume several things about the inputs:
- Software changes polarity, phase and divider only while status bit 25 reads 1.
- In target mode, the external clock holds each phase for several system cycles.
- The external select moves only while that clock is idle.

Under these assumptions, the idle-level and select properties describe the block's intended behaviour. The bench reconfigures only after polling for done. It drives each external clock phase for eight system cycles and toggles the external select only when the clock is idle. In controller mode it loops the data output back to the input.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam logic [2:0] ADR_CFG  = 3'd0;
  localparam logic [2:0] ADR_DIV  = 3'd1;
  localparam logic [2:0] ADR_SEL  = 3'd2;
  localparam logic [2:0] ADR_STAT = 3'd3;
  localparam logic [2:0] ADR_TXD  = 3'd4;
  localparam logic [2:0] ADR_RXD  = 3'd5;

  localparam int STAT_DONE  = 25;
  localparam int STAT_RXLVL = 15;
  localparam int STAT_TXLVL = 6;
  localparam int LVL_FIELD  = 9;

  // Field order matches bit positions 5..0 of the configuration word
  typedef struct packed {
    logic srst;
    logic target;
    logic cpol;
    logic cpha;
    logic rx_en;
    logic tx_en;
  } cfg_t;
endpackage

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;

  assign full  = (cnt == LW'(DEPTH));
  assign empty = (cnt == '0);
  assign level = cnt;
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push && !full && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push && !full) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop && !empty) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + LW'(push && !full) - LW'(pop && !empty);
    end
  end
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            target,
  input  logic            tx_en,
  input  logic [DIVW-1:0] div,
  input  logic            tx_avail,
  input  logic [7:0]      tx_byte,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [7:0]      rx_byte,
  output logic            busy,
  output logic            sclk_o,
  output logic            sdo,
  input  logic            sdi,
  input  logic            sclk_i,
  input  logic            csn_i
);
  localparam int EDGES = 16;
  localparam int EW    = $clog2(EDGES);

  logic [1:0]      sclk_sy, sdi_sy, csn_sy;
  logic            sclk_q, sclk_r;
  logic [DIVW-1:0] cnt;
  logic [EW-1:0]   eidx;
  logic [7:0]      tx_sr, rx_sr;
  logic            start, tick, samp, shft, sdi_v;

  always_comb begin
    start  = !clr && !busy && (target ? !csn_sy[1] : (tx_en && tx_avail));
    tx_pop = start && tx_en && tx_avail;
    tick   = busy && (target ? (sclk_sy[1] != sclk_q) : (cnt == div));
    samp   = tick && (eidx[0] == cpha);
    shft   = tick && (eidx[0] != cpha) && (eidx != '0);
    sdi_v  = target ? sdi_sy[1] : sdi;
  end

  assign sdo     = tx_sr[7];
  assign sclk_o  = sclk_r;
  assign rx_byte = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0; sdi_sy <= '0; csn_sy <= 2'b11; sclk_q <= 1'b0;
      busy <= 1'b0; cnt <= '0; eidx <= '0; sclk_r <= 1'b0;
      tx_sr <= '0; rx_sr <= '0; rx_push <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_i};
      sdi_sy  <= {sdi_sy[0], sdi};
      csn_sy  <= {csn_sy[0], csn_i};
      sclk_q  <= sclk_sy[1];
      rx_push <= 1'b0;
      if (clr) begin
        busy <= 1'b0; cnt <= '0; eidx <= '0; sclk_r <= cpol;
      end else if (start) begin
        busy   <= 1'b1;
        tx_sr  <= tx_pop ? tx_byte : 8'h00;
        cnt    <= '0;
        eidx   <= '0;
        sclk_r <= cpol;
      end else if (busy && target && csn_sy[1]) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          if (!target) sclk_r <= ~sclk_r;
          if (samp) rx_sr <= {rx_sr[6:0], sdi_v};
          if (shft) tx_sr <= {tx_sr[6:0], 1'b0};
          eidx <= eidx + 1'b1;
          if (eidx == EW'(EDGES - 1)) begin
            busy    <= 1'b0;
            rx_push <= 1'b1;
          end
        end
      end else begin
        sclk_r <= cpol;
      end
    end
  end
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DIVW  = 8,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sclk_o,
  output logic        sdo_o,
  output logic        cs_n_o,
  input  logic        sdi_i,
  input  logic        sclk_i,
  input  logic        cs_n_i
);
  cfg_t            cfg;
  logic [DIVW-1:0] div_r;
  logic            cs_auto, cs_man, csn_r;
  logic            tx_ovr, rx_udr, rx_ovr;
  logic            srst, wr_txd, rd_rxd;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [LVLW-1:0] tx_lvl, rx_lvl;
  logic [7:0]      tx_head, rx_head, sh_rx_byte;
  logic            tx_pop, sh_rx_push, busy, done;
  logic            rx_keep;
  logic [31:0]     stat;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata[31:8];
  assign srst    = cfg.srst;
  assign wr_txd  = reg_wr && (reg_addr == ADR_TXD);
  assign rd_rxd  = reg_rd && (reg_addr == ADR_RXD);
  assign rx_keep = sh_rx_push && cfg.rx_en;
  assign done    = tx_empty && !busy;

  spi_ctl_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .push(wr_txd && !srst), .din(reg_wdata[7:0]),
    .pop(tx_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty), .level(tx_lvl));

  spi_ctl_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .push(rx_keep && !srst), .din(sh_rx_byte),
    .pop(rd_rxd && !srst), .dout(rx_head),
    .full(rx_full), .empty(rx_empty), .level(rx_lvl));

  spi_ctl_shift #(.DIVW(DIVW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .cpol(cfg.cpol), .cpha(cfg.cpha), .target(cfg.target), .tx_en(cfg.tx_en),
    .div(div_r), .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
    .rx_push(sh_rx_push), .rx_byte(sh_rx_byte), .busy(busy),
    .sclk_o(sclk_o), .sdo(sdo_o), .sdi(sdi_i), .sclk_i(sclk_i), .csn_i(cs_n_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; div_r <= DIVW'(3); cs_auto <= 1'b0; cs_man <= 1'b1; csn_r <= 1'b1;
      tx_ovr <= 1'b0; rx_udr <= 1'b0; rx_ovr <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADR_CFG) cfg <= cfg_t'(reg_wdata[5:0]);
      if (reg_wr && reg_addr == ADR_DIV) div_r <= reg_wdata[DIVW-1:0];
      if (reg_wr && reg_addr == ADR_SEL) begin
        cs_auto <= reg_wdata[1];
        cs_man  <= reg_wdata[0];
      end
      csn_r <= cs_auto ? !(busy || !tx_empty) : cs_man;
      if (srst) begin
        tx_ovr <= 1'b0; rx_udr <= 1'b0; rx_ovr <= 1'b0;
      end else begin
        if (wr_txd && tx_full)   tx_ovr <= 1'b1;
        if (rd_rxd && rx_empty)  rx_udr <= 1'b1;
        if (rx_keep && rx_full)  rx_ovr <= 1'b1;
      end
    end
  end

  assign cs_n_o = csn_r;

  always_comb begin
    stat = '0;
    stat[STAT_DONE] = done;
    stat[STAT_RXLVL +: LVL_FIELD] = LVL_FIELD'(rx_lvl);
    stat[STAT_TXLVL +: LVL_FIELD] = LVL_FIELD'(tx_lvl);
    stat[2] = rx_ovr;
    stat[1] = rx_udr;
    stat[0] = tx_ovr;
    case (reg_addr)
      ADR_CFG:  reg_rdata = {26'd0, cfg};
      ADR_DIV:  reg_rdata = 32'(div_r);
      ADR_SEL:  reg_rdata = {30'd0, cs_auto, cs_man};
      ADR_STAT: reg_rdata = stat;
      ADR_RXD:  reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_ctl_checker.sv
module spi_ctl_checker #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          cs_auto,
  input logic          cs_man,
  input logic          cs_n_o,
  input logic          busy,
  input logic          sclk_o,
  input logic          cpol,
  input logic          tx_en,
  input logic          wr_txd,
  input logic          tx_full,
  input logic          rd_rxd,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic [31:0]   reg_rdata
);
  assert_srst_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (tx_lvl == '0 && rx_lvl == '0));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_full && !tx_en && !srst) |=> (tx_lvl == $past(tx_lvl)));

  assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && rx_lvl == '0) |-> (reg_rdata == 32'd0));

  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sclk_o == $past(cpol)));

  assert_cs_auto_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_auto && busy) |=> !cs_n_o);

  assert_cs_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_auto |=> (cs_n_o == $past(cs_man)));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));
endmodule

bind spi_ctl_top spi_ctl_checker #(.DEPTH(DEPTH), .LW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .cs_auto(cs_auto), .cs_man(cs_man),
  .cs_n_o(cs_n_o), .busy(busy), .sclk_o(sclk_o), .cpol(cfg.cpol),
  .tx_en(cfg.tx_en), .wr_txd(wr_txd), .tx_full(tx_full), .rd_rxd(rd_rxd),
  .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .reg_rdata(reg_rdata));

// File: tb/spi_ctl_top_tb.sv
module spi_ctl_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sclk_o, sdo_o, cs_n_o;
  logic tb_target = 1'b0, tb_sclk = 1'b0, tb_csn = 1'b1, tb_mosi = 1'b0;
  logic tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [7:0] cap = '0;
  int capn = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  spi_ctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .cs_n_o(cs_n_o),
    .sdi_i(tb_target ? tb_mosi : sdo_o), .sclk_i(tb_sclk), .cs_n_i(tb_csn));

  // receiver model for R3: capture data output on the edges picked by polarity/phase
  always @(sclk_o) begin
    if (rst_n && !tb_target) begin
      if ((sclk_o != tb_cpol) ^ tb_cpha) begin
        cap  = {cap[6:0], sdo_o};
        capn = capn + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] txl(input logic [31:0] s); return (s >> 6) & 32'h1ff; endfunction
  function automatic logic [31:0] rxl(input logic [31:0] s); return (s >> 15) & 32'h1ff; endfunction

  task automatic wait_done(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin rd(3'd3, s); n++; end while (!s[25] && n < 4000);
    chk({tag, " done reached"}, 32'(s[25]), 32'd1);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    rd(3'd3, s);
    chk("R1 R5 status after reset", s, 32'h0200_0000);
    chk("R1 sclk idle low", 32'(sclk_o), 32'd0);
    chk("R1 select high", 32'(cs_n_o), 32'd1);
  endtask

  task automatic t_loop(input logic pol, input logic pha, input logic [7:0] dv,
                        input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [31:0] s, d;
    int n;
    logic [31:0] base;
    base = 32'(pol) << 3 | 32'(pha) << 2 | 32'h2;
    wr(3'd0, base); wr(3'd1, 32'(dv)); wr(3'd2, 32'h2);
    tb_cpol = pol; tb_cpha = pha;
    repeat (3) @(negedge clk);
    capn = 0;
    wr(3'd4, 32'(b0)); wr(3'd4, 32'(b1)); wr(3'd4, 32'(b2));
    repeat (20) @(negedge clk);
    rd(3'd3, s);
    chk("R4 R10 tx level held with transmit off", txl(s), 32'd3);
    chk("R5 not done with queued data", 32'(s[25]), 32'd0);
    chk("R8 auto select low while queued", 32'(cs_n_o), 32'd0);
    wr(3'd0, base | 32'h1);
    n = 0;
    while (sclk_o == pol && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (sclk_o != pol && n < 200) begin @(negedge clk); n++; end
    chk("R11 half period", 32'(n), 32'(dv) + 1);
    wait_done("R5");
    repeat (3) @(negedge clk);
    rd(3'd3, s);
    chk("R4 rx level after three bytes", rxl(s), 32'd3);
    chk("R4 tx level empty", txl(s), 32'd0);
    chk("R8 auto select released", 32'(cs_n_o), 32'd1);
    chk("R3 sampled bit count", 32'(capn), 32'd24);
    chk("R3 last byte on chosen edge", 32'(cap), 32'(b2));
    chk("R3 clock idles at polarity", 32'(sclk_o), 32'(pol));
    rd(3'd5, d); chk("R2 first byte", d, 32'(b0));
    rd(3'd5, d); chk("R2 second byte", d, 32'(b1));
    rd(3'd5, d); chk("R2 third byte", d, 32'(b2));
    wr(3'd0, 32'h0);
  endtask

  task automatic t_manual_cs;
    wr(3'd2, 32'h0); @(negedge clk);
    chk("R8 manual select low", 32'(cs_n_o), 32'd0);
    wr(3'd2, 32'h1); @(negedge clk);
    chk("R8 manual select high", 32'(cs_n_o), 32'd1);
  endtask

  task automatic t_underrun;
    logic [31:0] s, d;
    wr(3'd0, 32'h3);
    rd(3'd5, d);
    chk("R7 empty read returns zero", d, 32'd0);
    rd(3'd3, s);
    chk("R7 underrun flag", 32'(s[1]), 32'd1);
    wr(3'd0, 32'h20); wr(3'd0, 32'h0);
  endtask

  task automatic t_rx_off;
    logic [31:0] s;
    wr(3'd1, 32'd1);
    wr(3'd0, 32'h1);
    wr(3'd4, 32'h5A);
    wait_done("R10");
    repeat (3) @(negedge clk);
    rd(3'd3, s);
    chk("R10 receive disabled discards", rxl(s), 32'd0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_full;
    logic [31:0] s, d;
    wr(3'd0, 32'h2); wr(3'd1, 32'd0);
    for (int i = 0; i < 65; i++) wr(3'd4, 32'(i));
    rd(3'd3, s);
    chk("R6 level stays at depth", txl(s), 32'd64);
    chk("R6 overrun flag", 32'(s[0]), 32'd1);
    wr(3'd0, 32'h3);
    wait_done("R6");
    repeat (3) @(negedge clk);
    rd(3'd3, s);
    chk("R4 rx level full", rxl(s), 32'd64);
    chk("R13 no overflow yet", 32'(s[2]), 32'd0);
    wr(3'd4, 32'hEE);
    wait_done("R13");
    repeat (3) @(negedge clk);
    rd(3'd3, s);
    chk("R13 rx level stays full", rxl(s), 32'd64);
    chk("R13 overflow flag", 32'(s[2]), 32'd1);
    rd(3'd5, d);
    chk("R13 oldest byte kept", d, 32'd0);
    wr(3'd0, 32'h20);
    rd(3'd3, s);
    chk("R9 soft reset clears all", s, 32'h0200_0000);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_target;
    logic [31:0] s, d;
    logic [7:0] drv = 8'h3C;
    logic [7:0] got = '0;
    wr(3'd0, 32'h13);
    wr(3'd4, 32'hA5);
    tb_target = 1'b1;
    tb_csn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      tb_mosi = drv[i];
      repeat (8) @(negedge clk);
      got = {got[6:0], sdo_o};
      tb_sclk = 1'b1;
      repeat (8) @(negedge clk);
      tb_sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    tb_csn = 1'b1;
    repeat (8) @(negedge clk);
    rd(3'd3, s);
    chk("R12 one byte received", rxl(s), 32'd1);
    rd(3'd5, d);
    chk("R12 received byte", d, 32'h3C);
    chk("R12 driven byte", 32'(got), 32'hA5);
    tb_target = 1'b0;
    wr(3'd0, 32'h20); wr(3'd0, 32'h0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_loop(1'b0, 1'b0, 8'd1, 8'hC3, 8'h5A, 8'h81);
    t_loop(1'b1, 1'b1, 8'd2, 8'h0F, 8'hF0, 8'h96);
    t_loop(1'b0, 1'b1, 8'd0, 8'h01, 8'h80, 8'h7E);
    t_loop(1'b1, 1'b0, 8'd3, 8'hAA, 8'h55, 8'h3C);
    t_manual_cs();
    t_underrun();
    t_rx_off();
    t_full();
    t_target();
    finish_run();
  end
endmodule